// File: doc/BRIEF.md
# Video Controller Command Port Decoder

This block sits behind the control port of a video controller. Every 16-bit word written to that port is either a single-word register write or one half of a two-word access command. Register writes leave as a one-cycle strobe with index and value. A command is built from two words whose fields are spread across both words. Together they give a 6-bit access code and a 16-bit access address, and the block hands both to the data-port unit.

The block keeps private copies of the three registers it depends on: the auto-increment step, the mode register that holds the DMA enable, and the DMA configuration register. Each data-port access advances the address by the step. For colour-memory targets the advanced address wraps inside 7 bits. When the second word carries its transfer bit and DMA is enabled, the block raises a one-cycle DMA start along with the transfer mode. A read of the control port, or any data-port access, abandons a half-built command. The block also provides the byte-masked merge that a video-memory word write needs.

Top module: `vdp_cmd_decoder`

## Requirements
- R1: When no command is pending and bits 15:14 of a control write are 2'b10, the word is a register write with index in bits 12:8 and value in bits 7:0. In the next cycle regWrEn is high for exactly one cycle with that index and value. Code, address and the pending flag are unchanged.
- R2: When no command is pending and bits 15:14 are not 2'b10, the word is a first command word. Code bits 1:0 take data bits 15:14, address bits 13:0 take data bits 13:0, address bits 15:14 are kept, and the pending flag is set.
- R3: While a command is pending, any control write is the second word, whatever its top bits. Code bits 4:2 take data bits 6:4, code bit 5 takes data bit 7, and address bits 15:14 take data bits 1:0. Code bits 1:0 and address bits 13:0 are kept, and the pending flag clears.
- R4: A second word with bit 7 set, while bit 4 of register 1 is set, gives a one-cycle dmaStart in the next cycle, with dmaMode equal to bits 7:6 of register 23. Otherwise dmaStart stays low.
- R5: A data-port access (dataAcc) adds the zero-extended value of register 15 to the access address, modulo 2^16.
- R6: When code bits 3:0 are 4'h3 or 4'h8 (colour-memory targets), the address after an increment is masked to its low 7 bits. colourIdx always equals address bits 6:1.
- R7: mergedWord equals (oldWord & ~byteMask) | (newData & byteMask), combinationally.
- R8: A data-port access or a control read with no control write in the same cycle clears the pending flag. A control write in the same cycle takes priority, and the access or read is then ignored.
- R9: After reset, the pending flag, code, address, regWrEn and dmaStart are all zero.
- R10: A register write with an index of 24 or above gives no strobe and changes none of the held registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWr | input | 1 | Control port write strobe |
| ctrlRd | input | 1 | Control port read strobe |
| ctrlWrData | input | 16 | Control port write word |
| dataAcc | input | 1 | Data-port read or write performed |
| oldWord | input | 16 | Current video-memory word for merge |
| newData | input | 16 | Incoming data word for merge |
| byteMask | input | 16 | Lane mask for merge |
| mergedWord | output | 16 | Merged word |
| regWrEn | output | 1 | Register write strobe |
| regWrIdx | output | 5 | Register write index |
| regWrVal | output | 8 | Register write value |
| accAddr | output | 16 | Current access address |
| accCode | output | 6 | Current access code |
| colourIdx | output | 6 | Colour-memory word index |
| cmdPending | output | 1 | Second command word awaited |
| dmaStart | output | 1 | DMA start pulse |
| dmaMode | output | 2 | DMA mode with the start pulse |

## Verification
A wrong pending flag shows up on the very next control write. A register write is then taken as a second word, or a second word as a first, so the address or code goes wrong one cycle later and regWrEn is missing. A wrong held step or a bad colour wrap shows in accAddr one cycle after the next data access. A stale DMA configuration copy shows up only on a later second word with its transfer bit set. For that reason the bench compares every output on every cycle against its own model, so each fault is caught on its first visible cycle.

// File: rtl/vdp_cmd_pkg.sv
package vdp_cmd_pkg;
  localparam int ADDR_W = 16;
  localparam int CODE_W = 6;
  localparam int REG_W  = 8;
  localparam int IDX_W  = 5;

  typedef struct packed {
    logic regWr;
    logic firstWord;
    logic secondWord;
    logic advance;
  } cmdStrobe_t;
endpackage

// File: rtl/vdp_cmd_ctrl.sv
module vdp_cmd_ctrl
  import vdp_cmd_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctrlWr,
  input  logic       ctrlRd,
  input  logic       dataAcc,
  input  logic [1:0] prefix,
  output cmdStrobe_t strobe,
  output logic       pendingQ
);
  logic isRegWord;
  assign isRegWord = (prefix == 2'b10);

  always_comb begin
    strobe.regWr      = ctrlWr && !pendingQ && isRegWord;
    strobe.firstWord  = ctrlWr && !pendingQ && !isRegWord;
    strobe.secondWord = ctrlWr && pendingQ;
    strobe.advance    = !ctrlWr && dataAcc;
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      pendingQ <= 1'b0;
    else if (strobe.firstWord)
      pendingQ <= 1'b1;
    else if (strobe.secondWord)
      pendingQ <= 1'b0;
    else if (dataAcc || ctrlRd)
      pendingQ <= 1'b0;
  end

  p_pend_set_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !pendingQ && prefix != 2'b10) |=> pendingQ);
  p_pend_clear_r3: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && pendingQ) |=> !pendingQ);
  p_reg_keep_pend_r1: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !pendingQ && prefix == 2'b10) |=> !pendingQ);
  p_abandon_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!ctrlWr && (dataAcc || ctrlRd)) |=> !pendingQ);
endmodule

// File: rtl/vdp_cmd_path.sv
module vdp_cmd_path
  import vdp_cmd_pkg::*;
#(
  parameter int REG_CNT     = 24,
  parameter int AUTOINC_IDX = 15,
  parameter int MODE2_IDX   = 1,
  parameter int DMAEN_BIT   = 4,
  parameter int DMACFG_IDX  = 23,
  parameter int COLOUR_W    = 7
) (
  input  logic              clk,
  input  logic              rstN,
  input  cmdStrobe_t        strobe,
  input  logic [15:0]       wrData,
  output logic              regWrEn,
  output logic [IDX_W-1:0]  regWrIdx,
  output logic [REG_W-1:0]  regWrVal,
  output logic [ADDR_W-1:0] accAddr,
  output logic [CODE_W-1:0] accCode,
  output logic              dmaStart,
  output logic [1:0]        dmaMode
);
  localparam logic [IDX_W-1:0]  LAST_IDX    = IDX_W'(REG_CNT - 1);
  localparam logic [ADDR_W-1:0] COLOUR_MASK = ADDR_W'((1 << COLOUR_W) - 1);

  logic [REG_W-1:0] autoIncQ, mode2Q, dmaCfgQ;
  logic [IDX_W-1:0] wrIdx;
  logic             idxValid, colourTarget;
  logic [ADDR_W-1:0] stepSum, nextAddr;

  assign wrIdx    = wrData[12:8];
  assign idxValid = (wrIdx <= LAST_IDX);
  assign colourTarget = (accCode[3:0] == 4'h3) || (accCode[3:0] == 4'h8);
  assign stepSum  = accAddr + {{(ADDR_W-REG_W){1'b0}}, autoIncQ};
  assign nextAddr = colourTarget ? (stepSum & COLOUR_MASK) : stepSum;

  // shadow copies of the registers this block depends on
  always_ff @(posedge clk) begin
    if (!rstN) begin
      autoIncQ <= '0;
      mode2Q   <= '0;
      dmaCfgQ  <= '0;
    end else if (strobe.regWr && idxValid) begin
      if (wrIdx == IDX_W'(AUTOINC_IDX)) autoIncQ <= wrData[7:0];
      if (wrIdx == IDX_W'(MODE2_IDX))   mode2Q   <= wrData[7:0];
      if (wrIdx == IDX_W'(DMACFG_IDX))  dmaCfgQ  <= wrData[7:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      regWrEn  <= 1'b0;
      regWrIdx <= '0;
      regWrVal <= '0;
    end else begin
      regWrEn <= strobe.regWr && idxValid;
      if (strobe.regWr && idxValid) begin
        regWrIdx <= wrIdx;
        regWrVal <= wrData[7:0];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      accAddr <= '0;
      accCode <= '0;
    end else if (strobe.firstWord) begin
      accCode[1:0]  <= wrData[15:14];
      accAddr[13:0] <= wrData[13:0];
    end else if (strobe.secondWord) begin
      accCode[4:2]   <= wrData[6:4];
      accCode[5]     <= wrData[7];
      accAddr[15:14] <= wrData[1:0];
    end else if (strobe.advance) begin
      accAddr <= nextAddr;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dmaStart <= 1'b0;
      dmaMode  <= '0;
    end else begin
      dmaStart <= strobe.secondWord && wrData[7] && mode2Q[DMAEN_BIT];
      if (strobe.secondWord && wrData[7] && mode2Q[DMAEN_BIT])
        dmaMode <= dmaCfgQ[7:6];
    end
  end

  p_regwr_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> !regWrEn || $past(strobe.regWr));
  p_dma_src_r4: assert property (@(posedge clk) disable iff (!rstN)
    dmaStart |-> $past(strobe.secondWord && wrData[7]));
  p_colour_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && colourTarget) |=> (accAddr[ADDR_W-1:COLOUR_W] == '0));
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.firstWord && !strobe.secondWord && !strobe.advance) |=> $stable(accAddr));
  p_bad_idx_r10: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.regWr && !idxValid) |=> !regWrEn);
endmodule

// File: rtl/vdp_cmd_decoder.sv
module vdp_cmd_decoder
  import vdp_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ctrlWr,
  input  logic        ctrlRd,
  input  logic [15:0] ctrlWrData,
  input  logic        dataAcc,
  input  logic [15:0] oldWord,
  input  logic [15:0] newData,
  input  logic [15:0] byteMask,
  output logic [15:0] mergedWord,
  output logic        regWrEn,
  output logic [4:0]  regWrIdx,
  output logic [7:0]  regWrVal,
  output logic [15:0] accAddr,
  output logic [5:0]  accCode,
  output logic [5:0]  colourIdx,
  output logic        cmdPending,
  output logic        dmaStart,
  output logic [1:0]  dmaMode
);
  cmdStrobe_t strobe;

  vdp_cmd_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .ctrlWr(ctrlWr), .ctrlRd(ctrlRd),
    .dataAcc(dataAcc), .prefix(ctrlWrData[15:14]),
    .strobe(strobe), .pendingQ(cmdPending)
  );

  vdp_cmd_path i_path (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(ctrlWrData),
    .regWrEn(regWrEn), .regWrIdx(regWrIdx), .regWrVal(regWrVal),
    .accAddr(accAddr), .accCode(accCode),
    .dmaStart(dmaStart), .dmaMode(dmaMode)
  );

  assign colourIdx  = accAddr[6:1];
  assign mergedWord = (oldWord & ~byteMask) | (newData & byteMask);
endmodule

// File: tb/test_vdp_cmd_decoder.sv
module test_vdp_cmd_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic ctrlWr = 0, ctrlRd = 0, dataAcc = 0;
  logic [15:0] ctrlWrData = 0, oldWord = 0, newData = 0, byteMask = 0;
  logic [15:0] mergedWord, accAddr;
  logic regWrEn, cmdPending, dmaStart;
  logic [4:0] regWrIdx;
  logic [7:0] regWrVal;
  logic [5:0] accCode, colourIdx;
  logic [1:0] dmaMode;

  int errors = 0, checks = 0;
  bit finished = 0;

  // model state
  logic        mPend;
  logic [5:0]  mCode;
  logic [15:0] mAddr;
  logic [7:0]  mInc, mMode2, mDmaCfg;
  logic        eRegWr, eDma;
  logic [4:0]  eIdx;
  logic [7:0]  eVal;
  logic [1:0]  eMode;

  always #10 clk = ~clk;

  vdp_cmd_decoder i_vdp_cmd_decoder (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mergeRef(logic [15:0] o, logic [15:0] d, logic [15:0] m);
    return (o & ~m) | (d & m);
  endfunction

  task automatic modelStep(logic wr, logic rd, logic acc, logic [15:0] d);
    logic [15:0] s;
    eRegWr = 0; eDma = 0;
    if (wr) begin
      if (!mPend && d[15:14] == 2'b10) begin
        if (d[12:8] < 5'd24) begin
          eRegWr = 1; eIdx = d[12:8]; eVal = d[7:0];
          if (d[12:8] == 5'd15) mInc = d[7:0];
          if (d[12:8] == 5'd1)  mMode2 = d[7:0];
          if (d[12:8] == 5'd23) mDmaCfg = d[7:0];
        end
      end else if (!mPend) begin
        mCode[1:0] = d[15:14]; mAddr[13:0] = d[13:0]; mPend = 1;
      end else begin
        mCode[4:2] = d[6:4]; mCode[5] = d[7]; mAddr[15:14] = d[1:0]; mPend = 0;
        if (d[7] && mMode2[4]) begin eDma = 1; eMode = mDmaCfg[7:6]; end
      end
    end else if (acc) begin
      s = mAddr + {8'h00, mInc};
      if (mCode[3:0] == 4'h3 || mCode[3:0] == 4'h8) s = s & 16'h007f;
      mAddr = s; mPend = 0;
    end else if (rd) begin
      mPend = 0;
    end
  endtask

  task automatic compareAll();
    chk("R1/R8 pending", cmdPending, mPend);
    chk("R2/R3 code", accCode, mCode);
    chk("R2/R3/R5/R6 address", accAddr, mAddr);
    chk("R6 colourIdx", colourIdx, mAddr[6:1]);
    chk("R1/R10 regWrEn", regWrEn, eRegWr);
    if (eRegWr) begin
      chk("R1 regWrIdx", regWrIdx, eIdx);
      chk("R1 regWrVal", regWrVal, eVal);
    end
    chk("R4 dmaStart", dmaStart, eDma);
    if (eDma) chk("R4 dmaMode", dmaMode, eMode);
    chk("R7 mergedWord", mergedWord, mergeRef(oldWord, newData, byteMask));
  endtask

  // called at a negedge: drive, clock, check at next negedge
  task automatic step(logic wr, logic rd, logic acc, logic [15:0] d);
    ctrlWr = wr; ctrlRd = rd; dataAcc = acc; ctrlWrData = d;
    oldWord = 16'($urandom); newData = 16'($urandom);
    byteMask = ($urandom_range(0, 2) == 0) ? 16'hff00 :
               ($urandom_range(0, 1) == 0) ? 16'h00ff : 16'hffff;
    @(posedge clk);
    modelStep(wr, rd, acc, d);
    @(negedge clk);
    ctrlWr = 0; ctrlRd = 0; dataAcc = 0;
    compareAll();
  endtask

  initial begin
    #(20 * 200000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    mPend = 0; mCode = 0; mAddr = 0; mInc = 0; mMode2 = 0; mDmaCfg = 0;
    eRegWr = 0; eDma = 0; eIdx = 0; eVal = 0; eMode = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    // R9 reset state
    chk("R9 pending after reset", cmdPending, 0);
    chk("R9 code after reset", accCode, 0);
    chk("R9 address after reset", accAddr, 0);
    chk("R9 regWrEn after reset", regWrEn, 0);
    chk("R9 dmaStart after reset", dmaStart, 0);

    // R1 auto-increment 2, R10 out-of-range index
    step(1, 0, 0, 16'h8F02);
    step(1, 0, 0, 16'h9F55);
    // R6 colour write target, address 0x7E wraps to 0 after step
    step(1, 0, 0, 16'hC07E);
    step(1, 0, 0, 16'h0000);
    step(0, 0, 1, 16'h0000);
    step(0, 0, 1, 16'h0000);
    // R4 DMA: enable, mode 3
    step(1, 0, 0, 16'h8114);
    step(1, 0, 0, 16'h97C0);
    step(1, 0, 0, 16'h4000);
    step(1, 0, 0, 16'h0083);
    // R3 second word with 10 prefix
    step(1, 0, 0, 16'h1234);
    step(1, 0, 0, 16'h8050);
    // R8 abandon by read, by access, and write priority
    step(1, 0, 0, 16'h4321);
    step(0, 1, 0, 16'h0000);
    step(1, 0, 0, 16'h4321);
    step(0, 0, 1, 16'h0000);
    step(1, 0, 0, 16'h4321);
    step(1, 1, 1, 16'h0010);
    // R5 wrap modulo 2^16 with large step
    step(1, 0, 0, 16'h8FFF);
    step(1, 0, 0, 16'h7FFF);
    step(1, 0, 0, 16'h0003);
    step(0, 0, 1, 16'h0000);
    step(0, 0, 1, 16'h0000);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int op = $urandom_range(0, 9);
      logic [15:0] d = 16'($urandom);
      if (op < 3) begin
        int pick = $urandom_range(0, 3);
        d[15:13] = 3'b100;
        d[12:8] = (pick == 0) ? 5'd15 : (pick == 1) ? 5'd1 :
                  (pick == 2) ? 5'd23 : 5'($urandom);
        if (pick == 0) d[7:0] = 8'($urandom_range(0, 4));
        step(1, 0, 0, d);
      end else if (op < 6) begin
        if ($urandom_range(0, 2) == 0) d[15:14] = 2'b11;
        if ($urandom_range(0, 2) == 0) d[6:4] = 3'b000;
        step(1, $urandom_range(0, 4) == 0, $urandom_range(0, 4) == 0, d);
      end else if (op < 8) begin
        step(0, 0, 1, d);
      end else if (op == 8) begin
        step(0, 1, 0, d);
      end else begin
        step(0, 0, 0, d);
      end
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule